// File: doc/BRIEF.md
# External Memory Bus Controller

This block sits between an 8-bit processor core and three memory targets: internal RAM, internal ROM and an external parallel bus. Each core access is marked as code or data, and as read or write. The controller decodes the access and sends it to one target. It drives the external pins: a 16-bit address bus, an 8-bit data bus with an output enable, and four active-low strobes. Code reads, data reads, code writes and data writes each have their own strobe.

Two active-low pins can push code reads off-chip. One pin covers the upper half of code space and the other covers the lower half, so part or all of the internal ROM can be replaced by external memory.

Internal RAM always answers in one clock. ROM and external cycles are lengthened by a programmable wait-state count, from 0 to 3 extra clocks, which resets to 1. The core holds its request until the controller raises ready. Read data is valid in the same clock as ready.

Top module: `ext_mem_ctrl`

## Requirements
- R1: A data-space access with an address below `RAM_BYTES` (2048) goes to internal RAM (`ram_req_o` high, and `ram_we_o` high for a write with `ram_wdata_o` equal to the write data). A data-space access at any higher address goes to the external bus.
- R2: An external access pulls exactly one strobe low. A code read uses `code_rd_n_o`, a data read uses `data_rd_n_o`, a code write uses `code_wr_n_o` and a data write uses `data_wr_n_o`.
- R3: A code read with address bit 15 set goes to the external bus while `ext_hi_n_i` is low. Otherwise it goes to internal ROM, with `rom_req_o` high.
- R4: A code read with address bit 15 clear goes to the external bus while `ext_lo_n_i` is low. Otherwise it goes to internal ROM. Both pins may be low together.
- R5: An internal RAM access raises `core_ready_o` in its first clock, whatever the wait-state setting.
- R6: A ROM or external access holds `core_ready_o` low for W clocks and raises it in clock W+1, where W is the wait-state count. W is 1 after reset.
- R7: A write on the config port (`cfg_we_i` high at a clock edge) loads `cfg_wait_i` (0 to 3) as W for the accesses that follow.
- R8: `ext_data_oe_o` is high only during an external write, while its write strobe is low. During that time `ext_data_o` carries the core's write data.
- R9: On a read, `core_rdata_o` holds the data of the selected target in the clock where `core_ready_o` is high.
- R10: An access to internal RAM or internal ROM leaves all four external strobes high and `ext_data_oe_o` low.
- R11: A code-space write always goes to the external bus, whatever the override pins say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_req_i | input | 1 | Access request, held until ready |
| core_code_i | input | 1 | 1 = code space, 0 = data space |
| core_we_i | input | 1 | 1 = write, 0 = read |
| core_addr_i | input | 16 | Access address |
| core_wdata_i | input | 8 | Write data |
| core_rdata_o | output | 8 | Read data, valid with ready |
| core_ready_o | output | 1 | Last clock of the access |
| cfg_we_i | input | 1 | Wait-state register write enable |
| cfg_wait_i | input | 2 | New wait-state count |
| ext_hi_n_i | input | 1 | Upper code half goes off-chip, active low |
| ext_lo_n_i | input | 1 | Lower code half goes off-chip, active low |
| ram_req_o | output | 1 | Internal RAM select |
| ram_we_o | output | 1 | Internal RAM write |
| ram_addr_o | output | 16 | Internal RAM address |
| ram_wdata_o | output | 8 | Internal RAM write data |
| ram_rdata_i | input | 8 | Internal RAM read data |
| rom_req_o | output | 1 | Internal ROM select |
| rom_addr_o | output | 16 | Internal ROM address |
| rom_rdata_i | input | 8 | Internal ROM read data |
| ext_addr_o | output | 16 | External address bus |
| ext_data_o | output | 8 | External data bus, outgoing |
| ext_data_oe_o | output | 1 | External data bus drive enable |
| ext_data_i | input | 8 | External data bus, incoming |
| code_rd_n_o | output | 1 | Code read strobe, active low |
| data_rd_n_o | output | 1 | Data read strobe, active low |
| code_wr_n_o | output | 1 | Code write strobe, active low |
| data_wr_n_o | output | 1 | Data write strobe, active low |

## Verification
Routing, strobes and the output enable are combinational on the held request. The bench therefore checks them one time unit after it drives a request on the falling edge, before any rising edge. Ready is due in the first clock for RAM and in clock W+1 for ROM and external targets. The bench counts falling edges from the request until ready, sampling after each rising edge has settled, and compares the count with a wait-state value it tracks itself from its own config writes. Read data is compared in the clock where ready is seen. Write data, RAM write enables and the output enable are compared in the first clock of the access.

// File: rtl/emc_pkg.sv
package emc_pkg;
  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_ROM = 2'd1,
    TGT_EXT = 2'd2
  } tgt_e;
endpackage

// File: rtl/emc_decode.sv
module emc_decode
  import emc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RAM_BYTES = 2048
) (
  input  logic              code_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ext_hi_n_i,
  input  logic              ext_lo_n_i,
  output tgt_e              tgt_o
);
  localparam int                HI_BIT    = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] RAM_LIMIT = ADDR_W'(RAM_BYTES);

  logic hi_half, off_chip_code;

  assign hi_half       = addr_i[HI_BIT];
  assign off_chip_code = (hi_half && !ext_hi_n_i) || (!hi_half && !ext_lo_n_i);

  always_comb begin
    if (!code_i)            tgt_o = (addr_i < RAM_LIMIT) ? TGT_RAM : TGT_EXT;
    else if (we_i)          tgt_o = TGT_EXT;  // ROM is not writable
    else if (off_chip_code) tgt_o = TGT_EXT;
    else                    tgt_o = TGT_ROM;
  end
endmodule

// File: rtl/emc_wait.sv
module emc_wait #(
  parameter int          WAIT_W   = 2,
  parameter logic [WAIT_W-1:0] WAIT_RST = WAIT_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              req_i,
  input  logic              stretch_i,
  output logic [WAIT_W-1:0] ws_o,
  output logic              ready_o
);
  logic [WAIT_W-1:0] ws_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ws_q <= WAIT_RST;
    else if (cfg_we_i) ws_q <= cfg_wait_i;
  end

  // >= keeps the cycle bounded if the setting drops mid-access
  assign ready_o = req_i && (!stretch_i || (cnt_q >= ws_q));
  assign ws_o    = ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!req_i || ready_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_RAM_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !stretch_i |-> ready_o); // R5
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> ws_q == $past(cfg_wait_i)); // R7
endmodule

// File: rtl/emc_bus.sv
module emc_bus
  import emc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              code_i,
  input  logic              we_i,
  input  tgt_e              tgt_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic              rom_req_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o,
  output logic              code_rd_n_o,
  output logic              data_rd_n_o,
  output logic              code_wr_n_o,
  output logic              data_wr_n_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic ext_act;

  assign ext_act   = req_i && (tgt_i == TGT_EXT);
  assign ram_req_o = req_i && (tgt_i == TGT_RAM);
  assign ram_we_o  = ram_req_o && we_i;
  assign rom_req_o = req_i && (tgt_i == TGT_ROM);

  assign code_rd_n_o = !(ext_act &&  code_i && !we_i);
  assign data_rd_n_o = !(ext_act && !code_i && !we_i);
  assign code_wr_n_o = !(ext_act &&  code_i &&  we_i);
  assign data_wr_n_o = !(ext_act && !code_i &&  we_i);

  assign ext_data_o    = wdata_i;
  assign ext_data_oe_o = ext_act && we_i;

  always_comb begin
    unique case (tgt_i)
      TGT_RAM: rdata_o = ram_rdata_i;
      TGT_ROM: rdata_o = rom_rdata_i;
      default: rdata_o = ext_data_i;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({code_rd_n_o, data_rd_n_o, code_wr_n_o, data_wr_n_o}) >= 3); // R2
  AST_SINGLE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_req_o, rom_req_o, !(code_rd_n_o && data_rd_n_o && code_wr_n_o && data_wr_n_o)})); // R1
endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import emc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int RAM_BYTES = 2048,
  parameter int WAIT_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_req_i,
  input  logic              core_code_i,
  input  logic              core_we_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic [DATA_W-1:0] core_rdata_o,
  output logic              core_ready_o,
  input  logic              cfg_we_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              ext_hi_n_i,
  input  logic              ext_lo_n_i,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              rom_req_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              code_rd_n_o,
  output logic              data_rd_n_o,
  output logic              code_wr_n_o,
  output logic              data_wr_n_o
);
  tgt_e              tgt;
  logic [WAIT_W-1:0] ws;
  logic              stretch;

  assign ram_addr_o  = core_addr_i;
  assign ram_wdata_o = core_wdata_i;
  assign rom_addr_o  = core_addr_i;
  assign ext_addr_o  = core_addr_i;
  assign stretch     = (tgt != TGT_RAM);

  emc_decode #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES)) u_decode (
    .code_i     (core_code_i),
    .we_i       (core_we_i),
    .addr_i     (core_addr_i),
    .ext_hi_n_i (ext_hi_n_i),
    .ext_lo_n_i (ext_lo_n_i),
    .tgt_o      (tgt)
  );

  emc_wait #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_wait_i (cfg_wait_i),
    .req_i      (core_req_i),
    .stretch_i  (stretch),
    .ws_o       (ws),
    .ready_o    (core_ready_o)
  );

  emc_bus #(.DATA_W(DATA_W)) u_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (core_req_i),
    .code_i        (core_code_i),
    .we_i          (core_we_i),
    .tgt_i         (tgt),
    .wdata_i       (core_wdata_i),
    .ram_rdata_i   (ram_rdata_i),
    .rom_rdata_i   (rom_rdata_i),
    .ext_data_i    (ext_data_i),
    .ram_req_o     (ram_req_o),
    .ram_we_o      (ram_we_o),
    .rom_req_o     (rom_req_o),
    .ext_data_o    (ext_data_o),
    .ext_data_oe_o (ext_data_oe_o),
    .code_rd_n_o   (code_rd_n_o),
    .data_rd_n_o   (data_rd_n_o),
    .code_wr_n_o   (code_wr_n_o),
    .data_wr_n_o   (data_wr_n_o),
    .rdata_o       (core_rdata_o)
  );

  AST_OE_WITH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_data_oe_o |-> (!code_wr_n_o || !data_wr_n_o)); // R8
  AST_INTERNAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_req_o || rom_req_o) |-> (code_rd_n_o && data_rd_n_o && code_wr_n_o && data_wr_n_o && !ext_data_oe_o)); // R10
  AST_FIRST_CLK_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_req_i) && !ram_req_o && (ws != '0) |-> !core_ready_o); // R6
  AST_CODE_WR_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_req_i && core_code_i && core_we_i |-> !code_wr_n_o); // R11
endmodule

// File: tb/ext_mem_ctrl_tb_top.sv
module ext_mem_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, code = 0, we = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ready;
  logic        cfg_we = 0;
  logic [1:0]  cfg_wait = '0;
  logic        hi_n = 1, lo_n = 1;
  logic        ram_req, ram_we, rom_req, oe;
  logic [15:0] ram_addr, rom_addr, ext_addr;
  logic [7:0]  ram_wdata, ram_rdata, rom_rdata, ext_do, ext_di;
  logic        crd_n, drd_n, cwr_n, dwr_n;

  int checks = 0, errors = 0;
  int wait_m = 1;

  always #10 clk = ~clk;

  assign ram_rdata = ram_addr[7:0] ^ 8'h3C;
  assign rom_rdata = rom_addr[7:0] ^ rom_addr[15:8] ^ 8'hA5;
  assign ext_di    = ext_addr[7:0] + 8'h11;

  ext_mem_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .core_req_i(req), .core_code_i(code), .core_we_i(we),
    .core_addr_i(addr), .core_wdata_i(wdata),
    .core_rdata_o(rdata), .core_ready_o(ready),
    .cfg_we_i(cfg_we), .cfg_wait_i(cfg_wait),
    .ext_hi_n_i(hi_n), .ext_lo_n_i(lo_n),
    .ram_req_o(ram_req), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .rom_req_o(rom_req), .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .ext_addr_o(ext_addr), .ext_data_o(ext_do), .ext_data_oe_o(oe),
    .ext_data_i(ext_di),
    .code_rd_n_o(crd_n), .data_rd_n_o(drd_n),
    .code_wr_n_o(cwr_n), .data_wr_n_o(dwr_n)
  );

  // 0 = RAM, 1 = ROM, 2 = external
  function automatic int exp_tgt(logic c, logic w, logic [15:0] a, logic h, logic l);
    if (!c) return (a < 16'd2048) ? 0 : 2;
    if (w) return 2;
    if ((a[15] && !h) || (!a[15] && !l)) return 2;
    return 1;
  endfunction

  function automatic logic [3:0] exp_strobes(int t, logic c, logic w);
    if (t != 2) return 4'b1111;
    case ({c, w})
      2'b10:   return 4'b0111;
      2'b00:   return 4'b1011;
      2'b11:   return 4'b1101;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(int t, logic [15:0] a);
    if (t == 0) return a[7:0] ^ 8'h3C;
    if (t == 1) return a[7:0] ^ a[15:8] ^ 8'hA5;
    return a[7:0] + 8'h11;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_wait(int v);
    @(negedge clk);
    cfg_we = 1; cfg_wait = 2'(v);
    @(negedge clk);
    cfg_we = 0;
    wait_m = v;
  endtask

  task automatic access(logic c, logic w, logic [15:0] a, logic [7:0] d);
    int t, n, exp_n;
    @(negedge clk);
    code = c; we = w; addr = a; wdata = d; req = 1;
    #1;
    t = exp_tgt(c, w, a, hi_n, lo_n);
    chk(t == 2 ? "R2 strobes" : "R10 strobes", {crd_n, drd_n, cwr_n, dwr_n}, exp_strobes(t, c, w));
    chk("R1 ram select", ram_req, t == 0);
    chk(a[15] ? "R3 rom select" : "R4 rom select", rom_req, t == 1);
    chk("R8 output enable", oe, (t == 2) && w);
    if (w && t == 2) chk("R8 write data", ext_do, d);
    if (w && t == 0) begin
      chk("R1 ram write enable", ram_we, 1);
      chk("R1 ram write data", ram_wdata, d);
    end
    if (c && w) chk("R11 code write strobe", cwr_n, 0);
    n = 1;
    while (!ready && n < 12) begin
      @(negedge clk); #1; n++;
    end
    exp_n = (t == 0) ? 1 : wait_m + 1;
    chk(t == 0 ? "R5 cycle length" : "R6 cycle length", n, exp_n);
    if (!w) chk("R9 read data", rdata, exp_rd(t, a));
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R10 idle strobes", {crd_n, drd_n, cwr_n, dwr_n}, 4'b1111);
    chk("R8 idle oe", oe, 0);
    // R6 reset wait of 1
    access(0, 0, 16'h1234, 8'h00);
    access(1, 0, 16'h0100, 8'h00);
    // R1 boundary
    access(0, 0, 16'h07FF, 8'h00);
    access(0, 1, 16'h07FF, 8'h5A);
    access(0, 0, 16'h0800, 8'h00);
    access(0, 1, 16'h0800, 8'hC7);
    // R3 / R4 overrides
    hi_n = 0;
    access(1, 0, 16'h8000, 8'h00);
    access(1, 0, 16'h7FFF, 8'h00);
    hi_n = 1; lo_n = 0;
    access(1, 0, 16'h7FFF, 8'h00);
    access(1, 0, 16'h8000, 8'h00);
    hi_n = 0;
    access(1, 0, 16'hFFFF, 8'h00);
    access(1, 0, 16'h0000, 8'h00);
    hi_n = 1; lo_n = 1;
    // R11 code write, R7 wait settings
    access(1, 1, 16'h4000, 8'h99);
    set_wait(0);
    access(0, 0, 16'h9000, 8'h00);
    access(0, 0, 16'h0010, 8'h00);
    set_wait(3);
    access(1, 0, 16'h2222, 8'h00);
    access(0, 0, 16'h0020, 8'h00);
    for (int i = 0; i < 120; i++) begin
      logic [15:0] ra;
      if (i % 15 == 0) set_wait(int'($urandom_range(0, 3)));
      hi_n = 1'($urandom); lo_n = 1'($urandom);
      ra = 16'($urandom);
      if ($urandom_range(0, 2) == 0) ra = {5'd0, ra[10:0]};
      access(1'($urandom), 1'($urandom), ra, 8'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule